// File: doc/BRIEF.md
# I2C Target Engine with Status Flags

This block is an I2C target (slave) for standard-mode buses. It runs entirely on a fast system clock that oversamples the open-drain SCL and SDA lines. Each line passes through a two-flop synchronizer and a three-sample agreement filter before any bus event is decoded. The block pulls SDA low through a single output enable and never drives it high.

Software programs a 7-bit own address and can choose to also accept the general call address. It hands over a byte for read transfers and picks up received bytes from a holding register. Progress appears in a status word. Two interrupt flags cover address/stop events and completed data bytes. Four state bits give the controller's last acknowledge, a collision indication, the transfer direction and the source of the last address/stop event.

On a collision the target drops off the bus for the rest of the transfer, and the next START or a software write clears the flag. SCL is never stretched, so the byte to be sent must be loaded before the controller clocks it out.

Top module: `i2c_target`

## Requirements
- R1: The address register (select 0) holds the own 7-bit address in bits 7:1 and a general call enable in bit 0; it resets to 0x00.
- R2: When the address byte matches, the target holds SDA low through the ninth clock of that byte. When it does not match, SDA stays released until the next START, and no data byte of that transfer is acknowledged.
- R3: The address byte 0x00 (general call, write) is acknowledged only while address register bit 0 is 1.
- R4: Status bit 1 holds the R/W bit of the last matched address byte: 1 for a controller read, 0 for a write.
- R5: In a write transfer each byte is taken MSB first and shown on rx_data. Status bit 6 (data flag) is set and the byte is acknowledged.
- R6: In a read transfer the byte loaded through select 1 is sent MSB first. The SDA enable changes only while SCL is low.
- R7: Status bit 4 holds the controller's last acknowledge bit after a sent byte (0 ACK, 1 NACK). After a NACK the target keeps SDA released until STOP or START.
- R8: If the target releases SDA to send a 1 but samples SDA low at the SCL rise, status bit 3 (collision) is set and the target drives nothing more in that transfer.
- R9: Writing 1 to status bit 3 (select 2) clears collision, and any START or repeated START also clears it.
- R10: Status bit 7 is set by a matched address (status bit 0 becomes 1) or by a STOP that ends an addressed transfer (status bit 0 becomes 0). A STOP after an unaddressed transfer leaves it alone.
- R11: Writing 1 to status bits 7 or 6 through select 2 clears them, and a write to select 1 also clears bit 6.
- R12: A low pulse of two system clocks or less on a line produces no bus event, while a longer low pulse on SDA with SCL high is taken as a START.
- R13: After reset the status word, rx_data and the SDA enable are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversampling the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | 0 address, 1 transmit byte, 2 status write-one-to-clear |
| reg_wdata_i | input | 8 | Register write data |
| rx_data_o | output | 8 | Last received data byte |
| status_o | output | 8 | Bit 7 addr/stop flag, 6 data flag, 4 received ack, 3 collision, 1 direction, 0 addr-or-stop source |

## Verification
The bench builds the block with its default parameters: a two-flop synchronizer, a three-sample filter and 8-bit bytes. It drives SCL with a 20-cycle half period. That is far faster than standard mode, but it still leaves about ten system clocks between an SCL fall and the controller's SDA change. This spacing is enough to check that the target's own SDA changes land inside the low phase. With the three-sample window, a two-cycle SDA pulse and an eight-cycle one fall on opposite sides of the filter threshold, so both the rejected glitch and the accepted START are reachable.

// File: rtl/i2c_tgt_pkg.sv
// Shared definitions for the I2C target: byte width, register selects,
// status bit positions, engine states and the decoded bus event bundle.
package i2c_tgt_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    localparam logic [1:0] SEL_ADDR = 2'd0;
    localparam logic [1:0] SEL_TXD  = 2'd1;
    localparam logic [1:0] SEL_STAT = 2'd2;

    localparam int STS_APIF  = 7;
    localparam int STS_DIF   = 6;
    localparam int STS_RXACK = 4;
    localparam int STS_COLL  = 3;
    localparam int STS_DIR   = 1;
    localparam int STS_AP    = 0;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_WAIT
    } tgt_state_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } bus_ev_t;

endpackage

// File: rtl/i2c_line_filter.sv
// Synchronizes one open-drain line and removes short pulses.
// Assumes the line idles high; the clean output only changes after
// FILT_LEN consecutive synchronized samples agree on the new level.
module i2c_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic clean_o
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [FILT_LEN-1:0]    win_q;
    logic                   clean_q;

    // Synchronizer chain and sample window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '1;
            win_q  <= '1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
            win_q  <= {win_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
        end
    end

    // Output follows the window only when every sample agrees.
    always_ff @(posedge clk) begin
        if (!rst_n)
            clean_q <= 1'b1;
        else if (&win_q)
            clean_q <= 1'b1;
        else if (~|win_q)
            clean_q <= 1'b0;
    end

    assign clean_o = clean_q;

    a_r12_rise_follows_sync: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clean_q) |-> $past(sync_q[SYNC_STAGES-1], 2));
    a_r12_fall_follows_sync: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clean_q) |-> !$past(sync_q[SYNC_STAGES-1], 2));

endmodule

// File: rtl/i2c_bus_events.sv
// Decodes SCL edges, START and STOP from the filtered lines.
// Assumes both inputs are already synchronized and glitch filtered.
module i2c_bus_events
    import i2c_tgt_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    scl_c,
    input  logic    sda_c,
    output bus_ev_t ev_o
);

    logic scl_d;
    logic sda_d;

    // One-cycle history of both clean lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_c;
            sda_d <= sda_c;
        end
    end

    // Edge and condition decode.
    always_comb begin
        ev_o.scl_rise = scl_c & ~scl_d;
        ev_o.scl_fall = ~scl_c & scl_d;
        ev_o.start    = scl_c & scl_d & sda_d & ~sda_c;
        ev_o.stop     = scl_c & scl_d & ~sda_d & sda_c;
        ev_o.sda      = sda_c;
    end

endmodule

// File: rtl/i2c_target.sv
// I2C target engine: address match with optional general call, byte
// receive and transmit, acknowledge handling, collision release and the
// status word. Assumes no clock stretching and a system clock many times
// faster than SCL, so every SCL phase spans several filtered samples.
module i2c_target
    import i2c_tgt_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic              reg_we_i,
    input  logic [1:0]        reg_sel_i,
    input  logic [BYTE_W-1:0] reg_wdata_i,
    output logic [BYTE_W-1:0] rx_data_o,
    output logic [BYTE_W-1:0] status_o
);

    localparam int N_LINES = 2;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

    logic [N_LINES-1:0] raw_lines;
    logic [N_LINES-1:0] clean_lines;
    bus_ev_t            ev;

    assign raw_lines = {sda_i, scl_i};

    for (genvar gi = 0; gi < N_LINES; gi++) begin : g_line
        i2c_line_filter #(
            .SYNC_STAGES (SYNC_STAGES),
            .FILT_LEN    (FILT_LEN)
        ) u_filt (
            .clk     (clk),
            .rst_n   (rst_n),
            .raw_i   (raw_lines[gi]),
            .clean_o (clean_lines[gi])
        );
    end

    i2c_bus_events u_events (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_c (clean_lines[0]),
        .sda_c (clean_lines[1]),
        .ev_o  (ev)
    );

    tgt_state_e        state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [BYTE_W-1:0] shreg_q, txsh_q, tx_reg_q, addr_reg_q, rx_data_q;
    logic              sda_oe_q, selected_q, dir_q;
    logic              apif_q, ap_q, dif_q, rxack_q, coll_q;

    logic addr_match, set_ap_addr, set_ap_stop, set_dif, set_coll, ack_sample;
    logic stat_wr, txd_wr;

    // Address compare and flag set/clear conditions.
    always_comb begin
        addr_match  = (shreg_q[BYTE_W-1:1] == addr_reg_q[BYTE_W-1:1]) ||
                      (addr_reg_q[0] && shreg_q == '0);
        set_ap_addr = ev.scl_fall && state_q == ST_ADDR && cnt_q == LAST_BIT && addr_match;
        set_ap_stop = ev.stop && selected_q;
        set_dif     = (ev.scl_fall && state_q == ST_RX && cnt_q == LAST_BIT) ||
                      (ev.scl_rise && state_q == ST_TX_ACK);
        set_coll    = ev.scl_rise && state_q == ST_TX && !sda_oe_q && !ev.sda;
        ack_sample  = ev.scl_rise && state_q == ST_TX_ACK;
        stat_wr     = reg_we_i && reg_sel_i == SEL_STAT;
        txd_wr      = reg_we_i && reg_sel_i == SEL_TXD;
    end

    // Software-written address and transmit registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_reg_q <= '0;
            tx_reg_q   <= '0;
        end else if (reg_we_i) begin
            if (reg_sel_i == SEL_ADDR) addr_reg_q <= reg_wdata_i;
            if (reg_sel_i == SEL_TXD)  tx_reg_q   <= reg_wdata_i;
        end
    end

    // Bus protocol sequencer: shifting, acknowledge and SDA drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            cnt_q      <= '0;
            shreg_q    <= '0;
            txsh_q     <= '0;
            rx_data_q  <= '0;
            sda_oe_q   <= 1'b0;
            selected_q <= 1'b0;
            dir_q      <= 1'b0;
        end else if (ev.start) begin
            state_q    <= ST_ADDR;
            cnt_q      <= '0;
            sda_oe_q   <= 1'b0;
            selected_q <= 1'b0;
        end else if (ev.stop) begin
            state_q    <= ST_IDLE;
            sda_oe_q   <= 1'b0;
            selected_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_ADDR, ST_RX: begin
                    if (ev.scl_rise) begin
                        shreg_q <= {shreg_q[BYTE_W-2:0], ev.sda};
                        cnt_q   <= cnt_q + 1'b1;
                    end else if (ev.scl_fall && cnt_q == LAST_BIT) begin
                        if (state_q == ST_RX) begin
                            rx_data_q <= shreg_q;
                            sda_oe_q  <= 1'b1;
                            state_q   <= ST_RX_ACK;
                        end else if (addr_match) begin
                            sda_oe_q   <= 1'b1;
                            selected_q <= 1'b1;
                            dir_q      <= shreg_q[0];
                            state_q    <= ST_ADDR_ACK;
                        end else begin
                            state_q <= ST_WAIT;
                        end
                    end
                end
                ST_ADDR_ACK, ST_RX_ACK: begin
                    if (ev.scl_fall) begin
                        cnt_q <= '0;
                        if (state_q == ST_ADDR_ACK && dir_q) begin
                            txsh_q   <= tx_reg_q;
                            sda_oe_q <= ~tx_reg_q[BYTE_W-1];
                            state_q  <= ST_TX;
                        end else begin
                            sda_oe_q <= 1'b0;
                            state_q  <= ST_RX;
                        end
                    end
                end
                ST_TX: begin
                    if (ev.scl_rise) begin
                        cnt_q <= cnt_q + 1'b1;
                        if (set_coll) begin
                            sda_oe_q <= 1'b0;
                            state_q  <= ST_WAIT;
                        end
                    end else if (ev.scl_fall) begin
                        if (cnt_q == LAST_BIT) begin
                            sda_oe_q <= 1'b0;
                            state_q  <= ST_TX_ACK;
                        end else begin
                            txsh_q   <= {txsh_q[BYTE_W-2:0], 1'b0};
                            sda_oe_q <= ~txsh_q[BYTE_W-2];
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (ev.scl_fall) begin
                        cnt_q <= '0;
                        if (!rxack_q) begin
                            txsh_q   <= tx_reg_q;
                            sda_oe_q <= ~tx_reg_q[BYTE_W-1];
                            state_q  <= ST_TX;
                        end else begin
                            sda_oe_q <= 1'b0;
                            state_q  <= ST_WAIT;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // Status flags: set by bus events, cleared by START or software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            apif_q  <= 1'b0;
            ap_q    <= 1'b0;
            dif_q   <= 1'b0;
            rxack_q <= 1'b0;
            coll_q  <= 1'b0;
        end else begin
            if (set_ap_addr || set_ap_stop) begin
                apif_q <= 1'b1;
                ap_q   <= set_ap_addr;
            end else if (stat_wr && reg_wdata_i[STS_APIF]) begin
                apif_q <= 1'b0;
            end
            if (set_dif)
                dif_q <= 1'b1;
            else if (txd_wr || (stat_wr && reg_wdata_i[STS_DIF]))
                dif_q <= 1'b0;
            if (ack_sample)
                rxack_q <= ev.sda;
            if (ev.start)
                coll_q <= 1'b0;
            else if (set_coll)
                coll_q <= 1'b1;
            else if (stat_wr && reg_wdata_i[STS_COLL])
                coll_q <= 1'b0;
        end
    end

    // Status word assembly.
    always_comb begin
        status_o            = '0;
        status_o[STS_APIF]  = apif_q;
        status_o[STS_DIF]   = dif_q;
        status_o[STS_RXACK] = rxack_q;
        status_o[STS_COLL]  = coll_q;
        status_o[STS_DIR]   = dir_q;
        status_o[STS_AP]    = ap_q;
    end

    assign sda_oe_o  = sda_oe_q;
    assign rx_data_o = rx_data_q;

    a_r8_coll_releases: assert property (@(posedge clk) disable iff (!rst_n)
        coll_q |-> !sda_oe_q);
    a_r9_start_clears_coll: assert property (@(posedge clk) disable iff (!rst_n)
        ev.start |=> !coll_q);
    a_r2_ack_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(apif_q) && ap_q) |-> sda_oe_q);
    a_r6_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_q) |-> !clean_lines[0]);
    a_r7_wait_released: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT) |-> !sda_oe_q);

endmodule

// File: tb/i2c_target_bench.sv
`timescale 1ns/1ps
module i2c_target_bench;

    localparam int H = 20;
    localparam int Q = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_low = 1'b0;
    logic       sda_low = 1'b0;
    logic       reg_we = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic       sda_oe;
    logic [7:0] rx_data;
    logic [7:0] status;
    logic       scl_line, sda_line;

    int n_tests = 0;
    int n_fail  = 0;
    logic quiet = 1'b0;
    logic [7:0] exp_q[$];

    assign scl_line = ~scl_low;
    assign sda_line = ~(sda_low | sda_oe);

    always #4 clk = ~clk;

    i2c_target u_i2c_target (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl_line),
        .sda_i       (sda_line),
        .sda_oe_o    (sda_oe),
        .reg_we_i    (reg_we),
        .reg_sel_i   (reg_sel),
        .reg_wdata_i (reg_wdata),
        .rx_data_o   (rx_data),
        .status_o    (status)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] sel, input logic [7:0] data);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic bus_start();
        sda_low = 1'b0; tick(Q);
        scl_low = 1'b0; tick(H);
        sda_low = 1'b1; tick(H);
        scl_low = 1'b1; tick(Q);
    endtask

    task automatic bus_stop();
        sda_low = 1'b1; tick(Q);
        scl_low = 1'b0; tick(H);
        sda_low = 1'b0; tick(H);
    endtask

    task automatic put_bit(input logic b);
        sda_low = ~b;   tick(Q);
        scl_low = 1'b0; tick(H);
        scl_low = 1'b1; tick(Q);
    endtask

    task automatic get_bit(output logic b, input logic force_low);
        sda_low = force_low; tick(Q);
        scl_low = 1'b0;      tick(Q);
        b = sda_line;        tick(Q);
        scl_low = 1'b1;      tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack);
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        get_bit(ack, 1'b0);
    endtask

    task automatic get_byte(output logic [7:0] d, input logic [7:0] force_mask);
        for (int i = 7; i >= 0; i--) get_bit(d[i], force_mask[i]);
    endtask

    // Scoreboard monitor: pops the expected byte on each write-mode data flag rise (R5).
    initial begin
        logic prev_dif = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n && status[6] && !prev_dif && !status[1]) begin
                if (exp_q.size() == 0) begin
                    n_tests++; n_fail++;
                    $display("FAIL R5 unexpected byte actual=0x%0h expected=none", rx_data);
                end else begin
                    check("R5 scoreboard rx byte", rx_data, exp_q.pop_front());
                end
            end
            prev_dif = status[6];
        end
    end

    // Line monitor: SDA enable moves only with SCL low (R6); no drive when quiet (R2/R7/R8).
    initial begin
        logic prev_oe = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n && scl_line && sda_oe != prev_oe) begin
                n_tests++; n_fail++;
                $display("FAIL R6 oe changed with SCL high actual=%0b expected=%0b", sda_oe, prev_oe);
            end
            if (rst_n && quiet && sda_oe) begin
                n_tests++; n_fail++;
                $display("FAIL R8 drive while released actual=1 expected=0");
            end
            prev_oe = sda_oe;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic       ack;
        logic [7:0] d;
        tick(5);
        rst_n = 1'b1;
        tick(5);
        check("R13 status after reset", status, 8'h00);
        check("R13 rx_data after reset", rx_data, 8'h00);
        check("R13 sda enable after reset", sda_oe, 0);

        // R1: own address 0x42, general call disabled
        reg_write(2'd0, 8'h84);

        // Write transfer
        exp_q.push_back(8'hA5);
        exp_q.push_back(8'h3C);
        bus_start();
        send_byte(8'h84, ack);
        check("R2 ack on matching address", ack, 0);
        check("R10 R4 addr flag, source 1, dir 0", status & 8'h83, 8'h81);
        reg_write(2'd2, 8'h80);
        check("R11 clear addr flag", status[7], 0);
        send_byte(8'hA5, ack);
        check("R5 byte acknowledged", ack, 0);
        check("R5 data flag set", status[6], 1);
        reg_write(2'd2, 8'h40);
        check("R11 clear data flag by status write", status[6], 0);
        send_byte(8'h3C, ack);
        check("R5 second byte acknowledged", ack, 0);
        reg_write(2'd1, 8'h00);
        check("R11 transmit write clears data flag", status[6], 0);
        bus_stop();
        tick(10);
        check("R10 stop flag, source 0", status & 8'h81, 8'h80);
        reg_write(2'd2, 8'hC0);

        // Mismatched address
        bus_start();
        send_byte(8'h26, ack);
        check("R2 no ack on mismatch", ack, 1);
        quiet = 1'b1;
        send_byte(8'h00, ack);
        check("R2 data ignored after mismatch", ack, 1);
        bus_stop();
        quiet = 1'b0;
        tick(10);
        check("R10 unaddressed stop leaves flag", status[7], 0);

        // General call disabled
        bus_start();
        send_byte(8'h00, ack);
        check("R3 general call ignored when disabled", ack, 1);
        bus_stop();

        // General call enabled
        reg_write(2'd0, 8'h85);
        exp_q.push_back(8'h77);
        bus_start();
        send_byte(8'h00, ack);
        check("R3 general call acknowledged when enabled", ack, 0);
        send_byte(8'h77, ack);
        check("R3 general call data acknowledged", ack, 0);
        bus_stop();
        reg_write(2'd2, 8'hC0);

        // Read transfer
        reg_write(2'd1, 8'hB2);
        bus_start();
        send_byte(8'h85, ack);
        check("R2 ack on read address", ack, 0);
        check("R4 direction read", status[1], 1);
        get_byte(d, 8'h00);
        check("R6 first read byte", d, 8'hB2);
        reg_write(2'd1, 8'h5E);
        put_bit(1'b0);
        check("R7 received ACK", status[4], 0);
        get_byte(d, 8'h00);
        check("R6 second read byte", d, 8'h5E);
        put_bit(1'b1);
        check("R7 received NACK", status[4], 1);
        tick(8);
        quiet = 1'b1;
        get_byte(d, 8'h00);
        check("R7 released after NACK", d, 8'hFF);
        reg_write(2'd2, 8'hC0);
        bus_stop();
        quiet = 1'b0;
        tick(10);
        check("R10 stop after read", status & 8'h81, 8'h80);
        reg_write(2'd2, 8'hC0);

        // Collision cleared by software
        reg_write(2'd1, 8'hF0);
        bus_start();
        send_byte(8'h85, ack);
        tick(8);
        quiet = 1'b1;
        get_byte(d, 8'h80);
        check("R8 target silent after collision", d, 8'h7F);
        check("R8 collision flag set", status[3], 1);
        put_bit(1'b1);
        bus_stop();
        quiet = 1'b0;
        tick(10);
        check("R9 stop keeps collision", status[3], 1);
        reg_write(2'd2, 8'h08);
        check("R9 collision cleared by write", status[3], 0);

        // Collision cleared by repeated START
        bus_start();
        send_byte(8'h85, ack);
        tick(8);
        get_byte(d, 8'h80);
        put_bit(1'b1);
        check("R8 collision set again", status[3], 1);
        bus_start();
        check("R9 collision cleared by START", status[3], 0);
        bus_stop();

        // Glitch filter
        bus_start();
        send_byte(8'h85, ack);
        tick(8);
        get_byte(d, 8'h80);
        put_bit(1'b1);
        bus_stop();
        tick(10);
        sda_low = 1'b1; tick(2);
        sda_low = 1'b0; tick(20);
        check("R12 short pulse ignored", status[3], 1);
        sda_low = 1'b1; tick(8);
        sda_low = 1'b0; tick(20);
        check("R12 long pulse is START", status[3], 0);

        check("R5 scoreboard drained", exp_q.size(), 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule